// File: doc/BRIEF.md
# Link Receiver Reinitialization Controller

This block sits on the receive side of a multi-lane serial converter link. It decides when the receiver should ask the far-end transmitter to restart link setup, and it signals that request by pulling the active-low `sync_n` line low. Each lane's alignment logic reports three kinds of fault into the block: lost code-group synchronization, frame misalignment and lane-to-lane misalignment. Any of these faults, or a request from software, sends the link back into its synchronization phase. A debug control can switch off the fault-driven path. When it is off, the faults are still recorded but no longer restart the link.

Every fault class has a sticky status bit that software clears by writing a one to it. A maskable interrupt is formed from those bits. Software can also start a multiframe-clock realignment, for example after a phase shift in the local timing reference. In that case the block first sends a one-cycle strobe that re-arms the SYSREF capture. It then waits for a fresh SYSREF rising edge, and only after that edge does it start the reinitialization.

The controller is a four-state machine:
- SYNC: the request is active and `sync_n` is low.
- DATA: the link is in its data phase.
- REARM: the strobe cycle.
- WAIT_SR: waiting for the SYSREF edge.

The transitions are:
- reset to SYNC;
- SYNC to DATA once the minimum hold has elapsed and all lanes report valid /K/ reception;
- DATA to REARM on a realignment command;
- DATA to SYNC on a software request or an enabled fault;
- REARM to WAIT_SR unconditionally;
- WAIT_SR to SYNC on a SYSREF rising edge.

Top module: `lrx_reinit_ctrl`

## Requirements
- R1: While reset is held and right after it, `sync_n` is 0, `err_status` is 0, `irq` is 0 and `sysref_rearm` is 0.
- R2: Once `sync_n` falls, it stays low for at least MF_CYCLES clock cycles and until every bit of `lane_k_ok` is 1. It returns high one cycle after both conditions hold. With `lane_k_ok` all ones throughout, it is low for exactly MF_CYCLES cycles.
- R3: In the data phase with `hw_reinit_dis` at 0, a 1 on any lane of `lane_cgs_err`, `lane_frame_err` or `lane_align_err` drives `sync_n` low on the next cycle.
- R4: With `hw_reinit_dis` at 1, lane fault flags never drive `sync_n` low.
- R5: In the data phase, `sw_reinit_req` drives `sync_n` low on the next cycle, whatever the value of `hw_reinit_dis`.
- R6: The bits of `err_status` are: bit 0 for code-group sync loss, bit 1 for frame misalignment, bit 2 for lane misalignment. A bit is set on the cycle after a fault of its class is seen in the data phase, whether or not `hw_reinit_dis` is set. A set bit holds until a cycle where the matching `status_clr` bit is 1. If a set and a clear arrive in the same cycle, the set wins.
- R7: `irq` is 1 exactly when some bit of `err_status` is 1 and the same bit of `irq_en` is 1.
- R8: A `realign_cmd` in the data phase makes `sysref_rearm` 1 for exactly one cycle, on the next cycle. Throughout this step `sync_n` stays high.
- R9: After the strobe, `sync_n` stays high until a rising edge of `sysref_in` occurs after the strobe cycle. It falls on the cycle after that edge. A level of `sysref_in` that was already high before the strobe does not count as an edge. A realignment works with `hw_reinit_dis` at 1.
- R10: Outside the data phase (SYNC, REARM, WAIT_SR), fault flags and `sw_reinit_req` are ignored. They set no status bit and change nothing about the reinitialization in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lane_cgs_err | input | NUM_LANES | Per-lane loss of code-group synchronization |
| lane_frame_err | input | NUM_LANES | Per-lane frame misalignment |
| lane_align_err | input | NUM_LANES | Per-lane lane-to-lane misalignment |
| lane_k_ok | input | NUM_LANES | Per-lane valid /K/ reception |
| sw_reinit_req | input | 1 | Software reinitialization request |
| hw_reinit_dis | input | 1 | Disables fault-driven reinitialization |
| irq_en | input | 3 | Interrupt enable per fault class |
| status_clr | input | 3 | Write-one-to-clear pulses for `err_status` |
| realign_cmd | input | 1 | Start a multiframe-clock realignment |
| sysref_in | input | 1 | SYSREF reference input |
| sync_n | output | 1 | Active-low reinitialization request to the transmitter |
| sysref_rearm | output | 1 | One-cycle strobe that re-arms SYSREF capture |
| err_status | output | 3 | Sticky fault-class status |
| irq | output | 1 | Interrupt |

## Verification
A state machine stuck in SYNC shows up as `sync_n` staying low after the minimum hold plus the /K/ wait. A machine that wrongly leaves SYNC shows up as `sync_n` rising after fewer than MF_CYCLES low cycles. Both are visible within one multiframe. A wrong transition out of DATA appears on the next cycle, either as `sync_n` falling when it should not or as it failing to fall. Faults in the realignment path appear as a missing or doubled `sysref_rearm` pulse, or as `sync_n` falling before the first genuine SYSREF edge. A status register that ignores the data-phase gate or the clear shows a wrong `err_status` or `irq` one cycle after the offending input.

// File: rtl/lrx_reinit_pkg.sv
package lrx_reinit_pkg;

    typedef enum logic [1:0] {
        ST_SYNC    = 2'd0,
        ST_DATA    = 2'd1,
        ST_REARM   = 2'd2,
        ST_WAIT_SR = 2'd3
    } lrx_state_e;

    localparam int ERR_CLASSES = 3;
    localparam int ERR_CGS     = 0;
    localparam int ERR_FRAME   = 1;
    localparam int ERR_LANE    = 2;

endpackage

// File: rtl/lrx_err_merge.sv
// Reduces per-lane fault flags to one hit per fault class, gated by the data phase.
module lrx_err_merge
    import lrx_reinit_pkg::*;
#(
    parameter int NUM_LANES = 4
) (
    input  logic [NUM_LANES-1:0]   cgs_err,
    input  logic [NUM_LANES-1:0]   frame_err,
    input  logic [NUM_LANES-1:0]   align_err,
    input  logic                   sample_en,
    output logic [ERR_CLASSES-1:0] class_hit
);

    logic [ERR_CLASSES-1:0][NUM_LANES-1:0] flags;

    assign flags[ERR_CGS]   = cgs_err;
    assign flags[ERR_FRAME] = frame_err;
    assign flags[ERR_LANE]  = align_err;

    for (genvar c = 0; c < ERR_CLASSES; c++) begin : g_class
        assign class_hit[c] = sample_en & (|flags[c]);
    end

endmodule

// File: rtl/lrx_err_status.sv
// Sticky status per fault class with write-one-to-clear and masked interrupt.
module lrx_err_status
    import lrx_reinit_pkg::*;
(
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [ERR_CLASSES-1:0] set_bits,
    input  logic [ERR_CLASSES-1:0] clr_bits,
    input  logic [ERR_CLASSES-1:0] enable,
    output logic [ERR_CLASSES-1:0] status,
    output logic                   irq
);

    for (genvar c = 0; c < ERR_CLASSES; c++) begin : g_bit
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                status[c] <= 1'b0;
            end else if (set_bits[c]) begin
                status[c] <= 1'b1;
            end else if (clr_bits[c]) begin
                status[c] <= 1'b0;
            end
        end
    end

    assign irq = |(status & enable);

endmodule

// File: rtl/lrx_mf_timer.sv
// Counts cycles spent in the sync phase; done once a full multiframe has elapsed.
module lrx_mf_timer #(
    parameter int MF_CYCLES = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic done
);

    localparam int CW = (MF_CYCLES > 2) ? $clog2(MF_CYCLES) : 1;
    localparam logic [CW-1:0] LAST = CW'(MF_CYCLES - 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            cnt <= '0;
        end else if (cnt != LAST) begin
            cnt <= cnt + 1'b1;
        end
    end

    assign done = run && (cnt == LAST);

endmodule

// File: rtl/lrx_sysref_edge.sv
// Rising-edge detector for the SYSREF reference input.
module lrx_sysref_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic sysref_in,
    output logic rise
);

    logic sysref_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sysref_q <= 1'b0;
        end else begin
            sysref_q <= sysref_in;
        end
    end

    assign rise = sysref_in & ~sysref_q;

endmodule

// File: rtl/lrx_reinit_ctrl.sv
// Receive-side link reinitialization controller.
module lrx_reinit_ctrl
    import lrx_reinit_pkg::*;
#(
    parameter int NUM_LANES = 4,
    parameter int MF_CYCLES = 16
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [NUM_LANES-1:0]   lane_cgs_err,
    input  logic [NUM_LANES-1:0]   lane_frame_err,
    input  logic [NUM_LANES-1:0]   lane_align_err,
    input  logic [NUM_LANES-1:0]   lane_k_ok,
    input  logic                   sw_reinit_req,
    input  logic                   hw_reinit_dis,
    input  logic [ERR_CLASSES-1:0] irq_en,
    input  logic [ERR_CLASSES-1:0] status_clr,
    input  logic                   realign_cmd,
    input  logic                   sysref_in,
    output logic                   sync_n,
    output logic                   sysref_rearm,
    output logic [ERR_CLASSES-1:0] err_status,
    output logic                   irq
);

    lrx_state_e state, state_nxt;

    logic                   in_data;
    logic [ERR_CLASSES-1:0] class_hit;
    logic                   hw_hit;
    logic                   mf_done;
    logic                   sr_rise;
    logic                   all_k;

    assign in_data = (state == ST_DATA);
    assign hw_hit  = |class_hit;
    assign all_k   = &lane_k_ok;

    lrx_err_merge #(.NUM_LANES(NUM_LANES)) u_merge (
        .cgs_err   (lane_cgs_err),
        .frame_err (lane_frame_err),
        .align_err (lane_align_err),
        .sample_en (in_data),
        .class_hit (class_hit)
    );

    lrx_err_status u_status (
        .clk      (clk),
        .rst_n    (rst_n),
        .set_bits (class_hit),
        .clr_bits (status_clr),
        .enable   (irq_en),
        .status   (err_status),
        .irq      (irq)
    );

    lrx_mf_timer #(.MF_CYCLES(MF_CYCLES)) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (state == ST_SYNC),
        .done  (mf_done)
    );

    lrx_sysref_edge u_edge (
        .clk       (clk),
        .rst_n     (rst_n),
        .sysref_in (sysref_in),
        .rise      (sr_rise)
    );

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_SYNC;
        end else begin
            state <= state_nxt;
        end
    end

    // Transitions
    always_comb begin
        state_nxt = state;
        unique case (state)
            ST_SYNC: begin
                if (mf_done && all_k) begin
                    state_nxt = ST_DATA;
                end
            end
            ST_DATA: begin
                if (realign_cmd) begin
                    state_nxt = ST_REARM;
                end else if (sw_reinit_req || (hw_hit && !hw_reinit_dis)) begin
                    state_nxt = ST_SYNC;
                end
            end
            ST_REARM: begin
                state_nxt = ST_WAIT_SR;
            end
            ST_WAIT_SR: begin
                if (sr_rise) begin
                    state_nxt = ST_SYNC;
                end
            end
            default: state_nxt = ST_SYNC;
        endcase
    end

    // Outputs
    always_comb begin
        sync_n       = 1'b1;
        sysref_rearm = 1'b0;
        unique case (state)
            ST_SYNC:    sync_n = 1'b0;
            ST_DATA:    sync_n = 1'b1;
            ST_REARM:   sysref_rearm = 1'b1;
            ST_WAIT_SR: sync_n = 1'b1;
            default:    sync_n = 1'b0;
        endcase
    end

endmodule

// File: rtl/lrx_reinit_chk.sv
module lrx_reinit_chk #(
    parameter int NUM_LANES = 4,
    parameter int MF_CYCLES = 16
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 sync_n,
    input logic                 sysref_rearm,
    input logic                 in_data,
    input logic                 err_any,
    input logic [NUM_LANES-1:0] lane_k_ok,
    input logic                 sw_reinit_req,
    input logic                 realign_cmd,
    input logic                 hw_reinit_dis,
    input logic [2:0]           err_status,
    input logic [2:0]           status_clr
);

    localparam int LW = $clog2(MF_CYCLES + 1) + 1;

    logic [LW-1:0] low_cnt;

    always_ff @(posedge clk) begin
        if (!rst_n || sync_n) begin
            low_cnt <= '0;
        end else if (low_cnt < LW'(MF_CYCLES)) begin
            low_cnt <= low_cnt + 1'b1;
        end
    end

    assert_min_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sync_n) |-> (low_cnt >= LW'(MF_CYCLES)));

    assert_k_before_release_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sync_n) |-> $past(&lane_k_ok));

    assert_hw_reinit_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (in_data && err_any && !hw_reinit_dis && !realign_cmd) |=> !sync_n);

    assert_hw_disabled_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (in_data && hw_reinit_dis && !sw_reinit_req && !realign_cmd) |=> sync_n);

    assert_sw_reinit_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (in_data && sw_reinit_req && !realign_cmd) |=> !sync_n);

    for (genvar c = 0; c < 3; c++) begin : g_sticky
        assert_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
            (err_status[c] && !status_clr[c]) |=> err_status[c]);
    end

    assert_rearm_start_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (in_data && realign_cmd) |=> (sysref_rearm && sync_n));

    assert_rearm_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
        sysref_rearm |=> (!sysref_rearm && sync_n));

    assert_ignore_outside_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!in_data && (status_clr == 3'b000)) |=> (err_status == $past(err_status)));

endmodule

bind lrx_reinit_ctrl lrx_reinit_chk #(
    .NUM_LANES (NUM_LANES),
    .MF_CYCLES (MF_CYCLES)
) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .sync_n        (sync_n),
    .sysref_rearm  (sysref_rearm),
    .in_data       (in_data),
    .err_any       (hw_hit),
    .lane_k_ok     (lane_k_ok),
    .sw_reinit_req (sw_reinit_req),
    .realign_cmd   (realign_cmd),
    .hw_reinit_dis (hw_reinit_dis),
    .err_status    (err_status),
    .status_clr    (status_clr)
);

// File: tb/lrx_reinit_ctrl_bench.sv
module lrx_reinit_ctrl_bench;

    localparam int NL = 4;
    localparam int MF = 16;

    logic          clk = 1'b0;
    logic          rst_n;
    logic [NL-1:0] lane_cgs_err, lane_frame_err, lane_align_err, lane_k_ok;
    logic          sw_reinit_req, hw_reinit_dis, realign_cmd, sysref_in;
    logic [2:0]    irq_en, status_clr, err_status;
    logic          sync_n, sysref_rearm, irq;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 0;

    always #5 clk = ~clk;

    lrx_reinit_ctrl #(.NUM_LANES(NL), .MF_CYCLES(MF)) u_lrx_reinit_ctrl (
        .clk(clk), .rst_n(rst_n),
        .lane_cgs_err(lane_cgs_err), .lane_frame_err(lane_frame_err),
        .lane_align_err(lane_align_err), .lane_k_ok(lane_k_ok),
        .sw_reinit_req(sw_reinit_req), .hw_reinit_dis(hw_reinit_dis),
        .irq_en(irq_en), .status_clr(status_clr), .realign_cmd(realign_cmd),
        .sysref_in(sysref_in), .sync_n(sync_n), .sysref_rearm(sysref_rearm),
        .err_status(err_status), .irq(irq)
    );

    function automatic logic [2:0] next_status(logic [2:0] cur, logic [2:0] hit, logic [2:0] clr);
        return (cur & ~clr) | hit;
    endfunction

    function automatic logic expect_irq(logic [2:0] st, logic [2:0] en);
        return |(st & en);
    endfunction

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    task automatic idle_inputs();
        lane_cgs_err = '0; lane_frame_err = '0; lane_align_err = '0;
        sw_reinit_req = 0; realign_cmd = 0; status_clr = '0;
    endtask

    task automatic wait_up(string req);
        for (int i = 0; i < 4 * MF; i++) begin
            if (sync_n) break;
            step();
        end
        chk(req, sync_n, 1'b1);
    endtask

    task automatic drive_err(int cls, int lane);
        case (cls)
            0: lane_cgs_err[lane]   = 1'b1;
            1: lane_frame_err[lane] = 1'b1;
            default: lane_align_err[lane] = 1'b1;
        endcase
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog: actual hang expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        logic [2:0] exp_st;
        int low_n;
        void'($urandom(32'h5eed_1234));
        rst_n = 0; lane_k_ok = '0; hw_reinit_dis = 0; irq_en = 3'b111; sysref_in = 0;
        idle_inputs();
        repeat (3) step();
        // R1 reset state
        chk("R1 sync_n", sync_n, 1'b0);
        chk("R1 status", err_status, 3'b000);
        chk("R1 irq", irq, 1'b0);
        chk("R1 rearm", sysref_rearm, 1'b0);
        rst_n = 1;
        step();
        chk("R1 sync_n after reset", sync_n, 1'b0);
        // R2: without /K/ on all lanes the request persists
        lane_k_ok = 4'b0111;
        repeat (MF + 6) step();
        chk("R2 held without all K", sync_n, 1'b0);
        lane_k_ok = '1;
        step();
        chk("R2 release after K", sync_n, 1'b1);

        // R5 software request and R2 exact hold length
        sw_reinit_req = 1;
        step();
        sw_reinit_req = 0;
        low_n = 0;
        for (int i = 0; i < 4 * MF; i++) begin
            if (sync_n) break;
            low_n++;
            step();
        end
        chk("R5 software request drops sync_n", low_n > 0, 1'b1);
        chk("R2 low length", low_n, MF);

        // R3 each fault class, R6 status, R7 irq, R10 ignored in SYNC
        for (int cls = 0; cls < 3; cls++) begin
            drive_err(cls, int'($urandom_range(NL - 1, 0)));
            step();
            idle_inputs();
            chk("R3 fault drops sync_n", sync_n, 1'b0);
            chk("R6 status class", err_status, 3'b001 << cls);
            chk("R7 irq raised", irq, 1'b1);
            lane_cgs_err = '1; lane_frame_err = '1; lane_align_err = '1; sw_reinit_req = 1;
            step();
            idle_inputs();
            chk("R10 faults ignored during reinit", err_status, 3'b001 << cls);
            wait_up("R2 recovers");
            status_clr = 3'b111;
            step();
            status_clr = '0;
            chk("R6 clear", err_status, 3'b000);
        end

        // R4/R6/R7 random faults with fault path disabled
        hw_reinit_dis = 1;
        exp_st = '0;
        for (int i = 0; i < 400; i++) begin
            logic [2:0] hit;
            lane_cgs_err   = ($urandom_range(7, 0) == 0) ? NL'($urandom) : '0;
            lane_frame_err = ($urandom_range(7, 0) == 0) ? NL'($urandom) : '0;
            lane_align_err = ($urandom_range(7, 0) == 0) ? NL'($urandom) : '0;
            status_clr     = ($urandom_range(3, 0) == 0) ? 3'($urandom) : '0;
            irq_en         = 3'($urandom);
            hit = {|lane_align_err, |lane_frame_err, |lane_cgs_err};
            exp_st = next_status(exp_st, hit, status_clr);
            step();
            chk("R4 sync_n stays high", sync_n, 1'b1);
            chk("R6 random status", err_status, exp_st);
            chk("R7 random irq", irq, expect_irq(exp_st, irq_en));
        end
        idle_inputs();
        irq_en = 3'b111;
        // R6 set wins over clear
        lane_frame_err = 4'b0100;
        status_clr = 3'b111;
        step();
        idle_inputs();
        chk("R6 set beats clear", err_status, 3'b010);
        status_clr = 3'b111;
        step();
        status_clr = '0;
        // R5 with fault path disabled
        sw_reinit_req = 1;
        step();
        sw_reinit_req = 0;
        chk("R5 software request while disabled", sync_n, 1'b0);
        wait_up("R2 recovers");

        // R8/R9 realignment, fault path still disabled
        realign_cmd = 1;
        step();
        realign_cmd = 0;
        chk("R8 strobe", sysref_rearm, 1'b1);
        chk("R8 sync_n high at strobe", sync_n, 1'b1);
        lane_cgs_err = '1;
        step();
        lane_cgs_err = '0;
        chk("R8 strobe single", sysref_rearm, 1'b0);
        chk("R9 wait holds sync_n", sync_n, 1'b1);
        repeat (5) step();
        chk("R9 still waiting", sync_n, 1'b1);
        chk("R10 fault ignored during wait", err_status, 3'b000);
        sysref_in = 1;
        step();
        chk("R9 edge issues reinit", sync_n, 1'b0);
        sysref_in = 0;
        wait_up("R2 recovers");

        // R9 SYSREF already high before the strobe does not count
        sysref_in = 1;
        realign_cmd = 1;
        step();
        realign_cmd = 0;
        chk("R8 strobe second", sysref_rearm, 1'b1);
        repeat (4) step();
        chk("R9 stale level ignored", sync_n, 1'b1);
        sysref_in = 0;
        step();
        chk("R9 falling edge ignored", sync_n, 1'b1);
        sysref_in = 1;
        step();
        chk("R9 fresh edge issues reinit", sync_n, 1'b0);
        sysref_in = 0;
        wait_up("R2 recovers");

        // R7 masking
        hw_reinit_dis = 1;
        irq_en = 3'b011;
        lane_align_err = 4'b0001;
        step();
        idle_inputs();
        chk("R7 masked irq", irq, 1'b0);
        irq_en = 3'b100;
        #1;
        chk("R7 unmasked irq", irq, 1'b1);

        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule